// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Latched Event Status

This block sits between an HDLC receive deframer and a host. The deframer hands over one byte per cycle when `in_valid` is high. Flags with each byte mark the opening byte of a message, the closing byte, a failed CRC check or an abort. Bytes that belong to a message are kept in a 64-entry queue. Each entry carries a tag that marks the first byte of a message. The host removes bytes one at a time through a pop port and sees the head byte and its tag on `out_data` / `out_first`.

Six kinds of event are caught and held in a status register that clears when read:
- the queue leaves the empty state;
- the fill level rises above a programmable watermark;
- a message opens;
- a message ends, well or badly;
- the head of the queue becomes the first byte of a message;
- a byte arrives while the queue is full.

A six-bit enable mask gates these held bits onto a single interrupt line.

Message reception is steered by a three-state machine:
- `RX_IDLE`: no message open.
- `RX_PKT`: a message is being stored.
- `RX_DROP`: the open message was cut off because the queue was full.

The transitions are:
- `RX_IDLE`→`RX_PKT` on an opening byte that is stored and does not close the message.
- `RX_PKT`→`RX_IDLE` on a closing byte, a CRC-error byte or an abort.
- `RX_PKT`→`RX_DROP` when a byte meets a full queue.
- `RX_DROP`→`RX_PKT` on the next opening byte.

An opening byte seen in any state starts a new message. If that same byte also closes the message, the machine goes back to `RX_IDLE`. If it meets a full queue, the machine goes to `RX_DROP`.

Top module: `hdlc_rxq_status`

## Requirements
- R1: The queue holds up to 64 bytes and delivers them in arrival order. `fill_count` gives the number held. `out_avail` is high when the count is non-zero. A pop while empty has no effect.
- R2: Each stored byte keeps a tag that is 1 exactly when the byte arrived with `in_sop`. The tag of the head entry is shown on `out_first`.
- R3: A message byte that arrives while 64 bytes are held is not stored. It sets status bit 5 (overrun) and bit 3 (packet end), and it closes the message. Later bytes without `in_sop` are discarded. The bytes already stored stay in the queue.
- R4: Status bit 4 is set when a byte tagged as first becomes the head of the queue. This happens either by a write into an empty queue or by a pop that exposes it.
- R5: Status bit 3 is set when a message byte arrives with `in_eop` or `in_crc_err`; that byte is stored. Bit 3 is also set when a message byte arrives with `in_abort`; that byte is not stored. In all three cases the message is closed.
- R6: Status bit 2 is set by every valid byte that carries `in_sop`.
- R7: Status bit 1 is set when `fill_count` goes from not greater than `wm_level` to greater than `wm_level`.
- R8: Status bit 0 is set when the queue goes from zero bytes to one or more bytes.
- R9: `stat_rdata` shows the six held bits in bits 5..0, and bits 7..6 read as 0. A read strobe clears the held bits at the next clock edge. An event in the same cycle as the read stays set. Without a read, held bits stay set.
- R10: `irq` is high exactly when some held bit is set whose mask bit is 1. The mask is written through `mask_wr` / `mask_wdata`.
- R11: A valid byte without `in_sop` that arrives while no message is open is discarded and raises no event.
- R12: After reset the queue is empty, all held bits and the mask are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte from the deframer is present |
| in_data | input | 8 | Received byte |
| in_sop | input | 1 | Byte opens a message |
| in_eop | input | 1 | Byte closes a message |
| in_crc_err | input | 1 | Message ended with a failed CRC check |
| in_abort | input | 1 | Abort seen; byte is not stored |
| wm_level | input | 6 | Watermark; the above condition is count > level |
| out_pop | input | 1 | Host removes the head byte |
| out_data | output | 8 | Head byte of the queue |
| out_first | output | 1 | Head byte opened its message |
| out_avail | output | 1 | Queue holds at least one byte |
| fill_count | output | 7 | Number of bytes held |
| stat_rd | input | 1 | Read strobe for the status register (clears it) |
| stat_rdata | output | 8 | Held event bits, upper two bits zero |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 6 | New interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The watermark condition is swept over every level from 0 to 63. For each level the queue is filled byte by byte to full, then overrun, then drained. This separates a crossing at exactly one fill level from an off-by-one threshold, a level-sensitive flag, or a missing empty-to-non-empty edge. Short messages closed by a good end, a CRC error and an abort are used to separate a stored closing byte from a discarded abort byte. A stray byte outside any message and an opening byte that arrives together with a status read are also applied. Draining several messages one pop at a time tells a head-of-message event apart from one raised at write time.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_PKT  = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

    localparam int NUM_EV    = 6;
    localparam int EV_NEMPTY = 0;
    localparam int EV_WMARK  = 1;
    localparam int EV_START  = 2;
    localparam int EV_END    = 3;
    localparam int EV_HEAD   = 4;
    localparam int EV_OVRUN  = 5;

endpackage

// File: rtl/hrq_rx_ctrl.sv
module hrq_rx_ctrl
    import hrq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_eop,
    input  logic in_crc_err,
    input  logic in_abort,
    input  logic fifo_full,
    output logic wr_en,
    output logic wr_first,
    output logic ev_start,
    output logic ev_end,
    output logic ev_ovr
);

    rx_state_e state_q, state_d;
    logic      take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        wr_en    = 1'b0;
        ev_end   = 1'b0;
        ev_ovr   = 1'b0;
        ev_start = in_valid & in_sop;
        wr_first = in_sop;
        unique case (state_q)
            RX_IDLE: take = in_valid & in_sop;
            RX_PKT:  take = in_valid;
            RX_DROP: take = in_valid & in_sop;
            default: take = 1'b0;
        endcase
        if (take) begin
            if (in_abort) begin
                ev_end  = 1'b1;
                state_d = RX_IDLE;
            end else if (fifo_full) begin
                ev_ovr  = 1'b1;
                ev_end  = 1'b1;
                state_d = RX_DROP;
            end else begin
                wr_en = 1'b1;
                if (in_eop | in_crc_err) begin
                    ev_end  = 1'b1;
                    state_d = RX_IDLE;
                end else begin
                    state_d = RX_PKT;
                end
            end
        end
    end

    assert_ovr_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovr |-> ev_end);
    assert_no_write_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !wr_en);
    assert_stray_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RX_PKT && !in_sop) |-> (!wr_en && !ev_end));
    assert_drop_leaves_on_sop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DROP && !(in_valid && in_sop)) |=> state_q == RX_DROP);

endmodule

// File: rtl/hrq_byte_fifo.sv
module hrq_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_first,
    input  logic          pop,
    input  logic [AW-1:0] wm_level,
    output logic [DW-1:0] rd_data,
    output logic          rd_first,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          ev_nempty,
    output logic          ev_wmark,
    output logic          ev_head
);

    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_pop;
    logic          empty_q, popped_q, above_q, above;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign do_pop = pop & ~empty;
    assign above  = (count > {1'b0, wm_level});

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= {wr_first, wr_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_en, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q  <= 1'b1;
            popped_q <= 1'b0;
            above_q  <= 1'b0;
        end else begin
            empty_q  <= empty;
            popped_q <= do_pop;
            above_q  <= above;
        end
    end

    assign rd_data   = mem[rd_ptr][DW-1:0];
    assign rd_first  = mem[rd_ptr][DW];
    assign ev_nempty = ~empty & empty_q;
    assign ev_wmark  = above & ~above_q;
    assign ev_head   = ~empty & rd_first & (empty_q | popped_q);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1
                  || count + 1'b1 == $past(count)));
    assert_nempty_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nempty |-> count == CW'(1));
    assert_pop_empty_noop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> count == '0);

endmodule

// File: rtl/hrq_evt_latch.sv
module hrq_evt_latch #(
    parameter int NEV = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_in,
    input  logic           rd,
    input  logic           mask_wr,
    input  logic [NEV-1:0] mask_wdata,
    output logic [NEV-1:0] stat_q,
    output logic           irq
);

    logic [NEV-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (rd ? '0 : stat_q) | ev_in;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    assign irq = |(stat_q & mask_q);

    assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_in) |=> ((stat_q & $past(ev_in)) == $past(ev_in)));
    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ev_in == '0) |=> stat_q == '0);
    assert_bits_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);

endmodule

// File: rtl/hdlc_rxq_status.sv
module hdlc_rxq_status
    import hrq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          in_crc_err,
    input  logic          in_abort,
    input  logic [AW-1:0] wm_level,
    input  logic          out_pop,
    output logic [DW-1:0] out_data,
    output logic          out_first,
    output logic          out_avail,
    output logic [CW-1:0] fill_count,
    input  logic          stat_rd,
    output logic [7:0]    stat_rdata,
    input  logic          mask_wr,
    input  logic [NUM_EV-1:0] mask_wdata,
    output logic          irq
);

    logic wr_en, wr_first, fifo_empty, fifo_full;
    logic ev_start, ev_end, ev_ovr, ev_nempty, ev_wmark, ev_head;
    logic [NUM_EV-1:0] ev_vec, stat_q;

    hrq_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_crc_err (in_crc_err),
        .in_abort   (in_abort),
        .fifo_full  (fifo_full),
        .wr_en      (wr_en),
        .wr_first   (wr_first),
        .ev_start   (ev_start),
        .ev_end     (ev_end),
        .ev_ovr     (ev_ovr)
    );

    hrq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (in_data),
        .wr_first  (wr_first),
        .pop       (out_pop),
        .wm_level  (wm_level),
        .rd_data   (out_data),
        .rd_first  (out_first),
        .count     (fill_count),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .ev_nempty (ev_nempty),
        .ev_wmark  (ev_wmark),
        .ev_head   (ev_head)
    );

    always_comb begin
        ev_vec            = '0;
        ev_vec[EV_NEMPTY] = ev_nempty;
        ev_vec[EV_WMARK]  = ev_wmark;
        ev_vec[EV_START]  = ev_start;
        ev_vec[EV_END]    = ev_end;
        ev_vec[EV_HEAD]   = ev_head;
        ev_vec[EV_OVRUN]  = ev_ovr;
    end

    hrq_evt_latch #(.NEV(NUM_EV)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_in      (ev_vec),
        .rd         (stat_rd),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .stat_q     (stat_q),
        .irq        (irq)
    );

    assign out_avail  = ~fifo_empty;
    assign stat_rdata = {{(8 - NUM_EV){1'b0}}, stat_q};

    assert_upper_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[7:6] == 2'b00);
    assert_avail_matches_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_avail == (fill_count != '0));

endmodule

// File: tb/hdlc_rxq_status_tb.sv
module hdlc_rxq_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic       in_crc_err = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = '0;
    logic [5:0] wm_level = 6'd63;
    logic       out_pop = 1'b0;
    logic [7:0] out_data;
    logic       out_first, out_avail;
    logic [6:0] fill_count;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       mask_wr = 1'b0;
    logic [5:0] mask_wdata = '0;
    logic       irq;

    always #2.5 clk = ~clk;

    hdlc_rxq_status dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_crc_err(in_crc_err),
        .in_abort(in_abort), .wm_level(wm_level), .out_pop(out_pop),
        .out_data(out_data), .out_first(out_first), .out_avail(out_avail),
        .fill_count(fill_count), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model
    logic [8:0] mq[$];
    bit         inpkt = 0;
    logic [5:0] exp_st = '0;
    logic [5:0] mmask = '0;
    int         wm = 63;

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_push(logic [7:0] d, bit s, bit e, bit c, bit a);
        int prev;
        prev = mq.size();
        if (s) begin
            exp_st[2] = 1'b1;
            inpkt = 1;
        end
        if (inpkt) begin
            if (a) begin
                exp_st[3] = 1'b1;
                inpkt = 0;
            end else if (prev == 64) begin
                exp_st[5] = 1'b1;
                exp_st[3] = 1'b1;
                inpkt = 0;
            end else begin
                mq.push_back({s, d});
                if (prev == 0) begin
                    exp_st[0] = 1'b1;
                    if (s) exp_st[4] = 1'b1;
                end
                if (prev == wm) exp_st[1] = 1'b1;
                if (e || c) begin
                    exp_st[3] = 1'b1;
                    inpkt = 0;
                end
            end
        end
    endtask

    task automatic push(logic [7:0] d, bit s, bit e, bit c, bit a);
        @(negedge clk);
        in_valid = 1; in_data = d; in_sop = s; in_eop = e;
        in_crc_err = c; in_abort = a;
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; in_crc_err = 0; in_abort = 0;
        model_push(d, s, e, c, a);
        chk("R1 count after byte", 32'(fill_count), 32'(mq.size()));
    endtask

    task automatic pop_one(string req);
        logic [8:0] f;
        @(negedge clk);
        f = mq[0];
        chk({req, " avail"}, 32'(out_avail), 32'd1);
        chk({req, " R1 data"}, 32'(out_data), 32'(f[7:0]));
        chk({req, " R2 tag"}, 32'(out_first), 32'(f[8]));
        out_pop = 1;
        @(negedge clk);
        out_pop = 0;
        void'(mq.pop_front());
        if (mq.size() > 0 && mq[0][8]) exp_st[4] = 1'b1;
        chk("R1 count after pop", 32'(fill_count), 32'(mq.size()));
    endtask

    task automatic read_stat(string req);
        @(negedge clk);
        stat_rd = 1;
        #1;
        chk({req, " status"}, 32'(stat_rdata), 32'({2'b00, exp_st}));
        @(negedge clk);
        stat_rd = 0;
        exp_st = '0;
    endtask

    task automatic set_mask(logic [5:0] m);
        @(negedge clk);
        mask_wr = 1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 0;
        mmask = m;
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 status", 32'(stat_rdata), 0);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 count", 32'(fill_count), 0);
        chk("R12 avail", 32'(out_avail), 0);

        // R6 R8 R4: first opening byte into an empty queue
        push(8'hA1, 1, 0, 0, 0);
        read_stat("R6 R8 R4 open");
        read_stat("R9 cleared");
        push(8'hA2, 0, 0, 0, 0);
        push(8'hA3, 0, 1, 0, 0);
        read_stat("R5 good end");
        // R11 stray byte outside a message
        push(8'h55, 0, 0, 0, 0);
        read_stat("R11 stray");
        // R5 CRC error end, byte stored
        push(8'hB1, 1, 0, 0, 0);
        push(8'hB2, 0, 1, 1, 0);
        read_stat("R5 crc end");
        // R5 abort, byte not stored
        push(8'hC1, 1, 0, 0, 0);
        push(8'hC2, 0, 0, 0, 1);
        read_stat("R5 abort");
        // R9 event in the same cycle as a read
        @(negedge clk);
        stat_rd = 1; in_valid = 1; in_sop = 1; in_data = 8'hD1;
        #1;
        chk("R9 read before event", 32'(stat_rdata), 0);
        @(negedge clk);
        stat_rd = 0; in_valid = 0; in_sop = 0;
        model_push(8'hD1, 1, 0, 0, 0);
        read_stat("R9 event kept over read");
        push(8'hD2, 0, 1, 0, 0);
        // R10 mask
        set_mask(6'h08);
        chk("R10 irq on", 32'(irq), 32'(|(exp_st & mmask)));
        set_mask(6'h20);
        chk("R10 irq masked", 32'(irq), 32'(|(exp_st & mmask)));
        set_mask(6'h00);
        read_stat("R5 end before drain");
        // drain: R4 head events as each message reaches the head
        while (mq.size() > 0) begin
            pop_one("drain");
            read_stat("R4 head");
        end
        // R1 pop on empty has no effect
        @(negedge clk);
        out_pop = 1;
        @(negedge clk);
        out_pop = 0;
        chk("R1 pop empty", 32'(fill_count), 0);
        read_stat("R1 pop empty no event");

        // sweep watermark levels: R7, R3, R8, R4
        for (int w = 0; w < 64; w++) begin
            @(negedge clk);
            wm = w;
            wm_level = 6'(w);
            for (int i = 0; i < 64; i++) begin
                push(8'((w * 7 + i) & 8'hFF), i == 0, 0, 0, 0);
                read_stat("R7 sweep fill");
            end
            push(8'hEE, 0, 0, 0, 0);
            read_stat("R3 overrun");
            push(8'hEF, 0, 0, 0, 0);
            read_stat("R3 discard after overrun");
            while (mq.size() > 0) begin
                pop_one("R3 sweep drain");
                read_stat("R4 sweep drain");
            end
        end
        chk("R1 final avail", 32'(out_avail), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule